// File: doc/BRIEF.md
# I2C Start/Stop Condition Detector

This block watches the SDA and SCL lines of a serial controller working in I2C mode and reports bus start and stop conditions. A start is SDA falling while SCL is high; a stop is SDA rising while SCL is high. An SDA edge counts only when it is qualified in time:

- **Setup:** SCL must already have been high for a minimum number of count-source ticks before the edge.
- **Hold:** SCL must then stay high for a minimum number of ticks after the edge.

Time is measured only in ticks of a baud-rate count-source enable, not in raw clock cycles.

Both condition types raise the same single-cycle interrupt request. A bus-busy flag lets software tell which event caused the request: a start sets it and a stop clears it. Two per-event pulses also come out alongside the request. Both line inputs are resynchronised into the block clock domain before any edge is looked for.

Top module: `i2c_cond_detect`

## Requirements
- R1: After reset `condIrq`, `startDet`, `stopDet` and `busBusy` are all 0.
- R2: A qualified falling SDA edge with SCL high produces one `condIrq` pulse together with a `startDet` pulse, and sets `busBusy` to 1.
- R3: A qualified rising SDA edge with SCL high produces one `condIrq` pulse together with a `stopDet` pulse, and clears `busBusy` to 0.
- R4: An SDA edge is ignored unless at least SETUP_TICKS ticks were seen while the synchronised SCL was high before the edge. Exactly SETUP_TICKS ticks is enough. An ignored edge leaves `busBusy` unchanged and raises no request.
- R5: A qualified edge is reported on the HOLD_TICKS-th tick after it. The outputs go high in the clock cycle right after the cycle in which that tick is sampled. HOLD_TICKS-1 ticks do not report.
- R6: If SCL goes low before the hold count completes, the pending condition is dropped and nothing is reported.
- R7: Setup and hold counting advance only in cycles where `tickEn` is 1. Any number of clock cycles without a tick never completes a count.
- R8: `condIrq` is high for exactly one clock cycle per event. Exactly one of `startDet` or `stopDet` is high with it, and neither is high without it.
- R9: SDA edges while SCL is low are never reported and do not change `busBusy`.
- R10: A new SDA edge that arrives while a condition is pending (SCL still high) replaces the pending one, and the hold count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Count-source tick enable, one clock wide per tick |
| sdaIn | input | 1 | Sampled SDA line level |
| sclIn | input | 1 | Sampled SCL line level |
| condIrq | output | 1 | Shared start/stop interrupt request pulse |
| busBusy | output | 1 | Bus-busy flag: set by start, cleared by stop |
| startDet | output | 1 | One-cycle start event pulse |
| stopDet | output | 1 | One-cycle stop event pulse |

## Verification
The bench builds the block with its default parameters: six setup ticks, six hold ticks and two synchroniser stages. With these values both qualification windows close within a few ticks. This puts the exact boundaries within reach: five versus six setup ticks, five versus six hold ticks, and the precise cycle of the reporting pulse. Sparse ticks, a spaced every fourth cycle, let each line change settle through the synchroniser between ticks. Each check can therefore name the tick on which a count ends.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_PEND_START = 2'd1,
    ST_PEND_STOP  = 2'd2
  } condState_t;

  typedef struct packed {
    logic setupClr;
    logic setupInc;
    logic holdClr;
    logic holdInc;
    logic fireStart;
    logic fireStop;
  } condStrobes_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[0] <= 1'b1;
          else       chain[0] <= lineIn;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[i] <= 1'b1;
          else       chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign lineOut = chain[STAGES-1];
endmodule

// File: rtl/i2c_cond_datapath.sv
module i2c_cond_datapath
  import i2c_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SETUP_TICKS = 6,
  parameter int HOLD_TICKS  = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sdaIn,
  input  logic         sclIn,
  input  condStrobes_t strobes,
  output logic         sclS,
  output logic         sdaRise,
  output logic         sdaFall,
  output logic         setupOk,
  output logic         holdDone,
  output logic         condIrq,
  output logic         busBusy,
  output logic         startDet,
  output logic         stopDet
);
  localparam int SetupW = $clog2(SETUP_TICKS + 1);
  localparam int HoldW  = $clog2(HOLD_TICKS + 1);
  localparam logic [SetupW-1:0] SetupLim = SETUP_TICKS[SetupW-1:0];
  localparam logic [HoldW-1:0]  HoldLast = HoldW'(HOLD_TICKS - 1);

  logic sdaS;
  logic sdaPrev;
  logic [SetupW-1:0] setupCnt;
  logic [HoldW-1:0]  holdCnt;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) uSdaSync (
    .clk(clk), .rstN(rstN), .lineIn(sdaIn), .lineOut(sdaS));
  i2c_line_sync #(.STAGES(SYNC_STAGES)) uSclSync (
    .clk(clk), .rstN(rstN), .lineIn(sclIn), .lineOut(sclS));

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) sdaPrev <= 1'b1;
    else       sdaPrev <= sdaS;

  assign sdaRise = sdaS & ~sdaPrev;
  assign sdaFall = ~sdaS & sdaPrev;

  // Setup counter: ticks seen with SCL high, saturating at the limit.
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                 setupCnt <= '0;
    else if (strobes.setupClr) setupCnt <= '0;
    else if (strobes.setupInc) setupCnt <= setupCnt + 1'b1;

  assign setupOk = (setupCnt >= SetupLim);

  // Hold counter: ticks since the pending edge.
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                holdCnt <= '0;
    else if (strobes.holdClr) holdCnt <= '0;
    else if (strobes.holdInc) holdCnt <= holdCnt + 1'b1;

  assign holdDone = (holdCnt == HoldLast);

  // Registered outputs.
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      condIrq  <= 1'b0;
      startDet <= 1'b0;
      stopDet  <= 1'b0;
      busBusy  <= 1'b0;
    end else begin
      condIrq  <= strobes.fireStart | strobes.fireStop;
      startDet <= strobes.fireStart;
      stopDet  <= strobes.fireStop;
      if (strobes.fireStart)     busBusy <= 1'b1;
      else if (strobes.fireStop) busBusy <= 1'b0;
    end
endmodule

// File: rtl/i2c_cond_control.sv
module i2c_cond_control
  import i2c_cond_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickEn,
  input  logic         sclS,
  input  logic         sdaRise,
  input  logic         sdaFall,
  input  logic         setupOk,
  input  logic         holdDone,
  output condStrobes_t strobes
);
  condState_t state, stateNext;
  logic sdaEdge;

  assign sdaEdge = sdaRise | sdaFall;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    strobes.setupClr = ~sclS;
    strobes.setupInc = sclS & tickEn & ~setupOk;

    if (!sclS) begin
      stateNext = ST_IDLE;
    end else if (sdaEdge) begin
      if (setupOk) begin
        strobes.holdClr = 1'b1;
        stateNext = sdaFall ? ST_PEND_START : ST_PEND_STOP;
      end else begin
        stateNext = ST_IDLE;
      end
    end else if (state != ST_IDLE && tickEn) begin
      if (holdDone) begin
        strobes.fireStart = (state == ST_PEND_START);
        strobes.fireStop  = (state == ST_PEND_STOP);
        stateNext = ST_IDLE;
      end else begin
        strobes.holdInc = 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
  import i2c_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SETUP_TICKS = 6,
  parameter int HOLD_TICKS  = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic sdaIn,
  input  logic sclIn,
  output logic condIrq,
  output logic busBusy,
  output logic startDet,
  output logic stopDet
);
  condStrobes_t strobes;
  logic sclS, sdaRise, sdaFall, setupOk, holdDone;

  i2c_cond_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .SETUP_TICKS(SETUP_TICKS), .HOLD_TICKS(HOLD_TICKS)
  ) uData (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .sclIn(sclIn), .strobes(strobes),
    .sclS(sclS), .sdaRise(sdaRise), .sdaFall(sdaFall), .setupOk(setupOk),
    .holdDone(holdDone), .condIrq(condIrq), .busBusy(busBusy),
    .startDet(startDet), .stopDet(stopDet));

  i2c_cond_control uCtrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .sclS(sclS), .sdaRise(sdaRise),
    .sdaFall(sdaFall), .setupOk(setupOk), .holdDone(holdDone), .strobes(strobes));
endmodule

// File: rtl/i2c_cond_checker.sv
module i2c_cond_checker (
  input logic clk,
  input logic rstN,
  input logic tickEn,
  input logic condIrq,
  input logic busBusy,
  input logic startDet,
  input logic stopDet
);
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    condIrq |=> !condIrq);
  p_irq_one_kind_r8: assert property (@(posedge clk) disable iff (!rstN)
    condIrq |-> (startDet ^ stopDet));
  p_flag_needs_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    (startDet | stopDet) |-> condIrq);
  p_busy_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    startDet |-> busBusy);
  p_busy_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |-> !busBusy);
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !condIrq |-> $stable(busBusy));
  p_irq_after_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    condIrq |-> $past(tickEn));
endmodule

bind i2c_cond_detect i2c_cond_checker uChk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .condIrq(condIrq),
  .busBusy(busBusy), .startDet(startDet), .stopDet(stopDet));

// File: tb/tb_i2c_cond_detect.sv
module tb_i2c_cond_detect;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic sdaIn = 1'b1;
  logic sclIn = 1'b1;
  logic condIrq, busBusy, startDet, stopDet;

  int nChecks = 0;
  int nFails  = 0;
  int irqCnt = 0, startCnt = 0, stopCnt = 0, wideIrq = 0;
  logic irqLast = 1'b0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  i2c_cond_detect dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .sdaIn(sdaIn), .sclIn(sclIn),
    .condIrq(condIrq), .busBusy(busBusy), .startDet(startDet), .stopDet(stopDet));

  always @(negedge clk) begin
    if (condIrq) irqCnt++;
    if (startDet) startCnt++;
    if (stopDet) stopCnt++;
    if (condIrq && irqLast) wideIrq++;
    irqLast = condIrq;
  end

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
      idle(2);
    end
  endtask

  task automatic busIdle();
    @(negedge clk); sclIn = 1'b0; idle(4);
    sdaIn = 1'b1; idle(4);
    sclIn = 1'b1; idle(4);
  endtask

  task automatic t_reset();
    chk("R1 irq", condIrq, 0);
    chk("R1 busy", busBusy, 0);
    chk("R1 start", startDet, 0);
    chk("R1 stop", stopDet, 0);
  endtask

  // R2 and R5: exact hold timing on a start
  task automatic t_start_exact();
    int i0 = irqCnt, s0 = startCnt;
    busIdle(); ticks(6);
    @(negedge clk); sdaIn = 1'b0; idle(4);
    ticks(5);
    chk("R5 no report after 5 hold ticks", irqCnt - i0, 0);
    @(negedge clk); tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
    chk("R5 irq one cycle after last tick", condIrq, 1);
    chk("R2 startDet", startDet, 1);
    chk("R2 busy set", busBusy, 1);
    @(negedge clk);
    chk("R8 irq dropped", condIrq, 0);
    idle(3);
    chk("R2 start count", startCnt - s0, 1);
  endtask

  // R3: stop from the busy state
  task automatic t_stop();
    int i0 = irqCnt, p0 = stopCnt;
    @(negedge clk); sdaIn = 1'b1; idle(4);
    ticks(6); idle(2);
    chk("R3 irq count", irqCnt - i0, 1);
    chk("R3 stop count", stopCnt - p0, 1);
    chk("R3 busy cleared", busBusy, 0);
  endtask

  // R4: five setup ticks do not qualify
  task automatic t_setup_short();
    int i0 = irqCnt;
    busIdle(); ticks(5);
    @(negedge clk); sdaIn = 1'b0; idle(4);
    ticks(8); idle(2);
    chk("R4 short setup ignored", irqCnt - i0, 0);
    chk("R4 busy unchanged", busBusy, 0);
  endtask

  // R6: SCL drops during hold
  task automatic t_hold_abort();
    int i0 = irqCnt;
    busIdle(); ticks(6);
    @(negedge clk); sdaIn = 1'b0; idle(4);
    ticks(3);
    @(negedge clk); sclIn = 1'b0; idle(4);
    sclIn = 1'b1; idle(4);
    ticks(8); idle(2);
    chk("R6 aborted hold not reported", irqCnt - i0, 0);
    chk("R6 busy unchanged", busBusy, 0);
  endtask

  // R7: no ticks, no progress
  task automatic t_no_tick();
    int i0 = irqCnt, s0 = startCnt;
    busIdle(); ticks(6);
    @(negedge clk); sdaIn = 1'b0;
    idle(200);
    chk("R7 no report without ticks", irqCnt - i0, 0);
    ticks(6); idle(2);
    chk("R7 report after ticks", startCnt - s0, 1);
    chk("R7 busy set", busBusy, 1);
  endtask

  // R9: SDA toggling while SCL low
  task automatic t_scl_low_edges();
    int i0 = irqCnt;
    @(negedge clk); sclIn = 1'b0; idle(4);
    for (int k = 0; k < 6; k++) begin
      sdaIn = ~sdaIn; ticks(3);
    end
    idle(2);
    chk("R9 data edges ignored", irqCnt - i0, 0);
    chk("R9 busy kept", busBusy, 1);
  endtask

  // R10: second edge replaces the pending one
  task automatic t_replace();
    int i0 = irqCnt, s0 = startCnt, p0 = stopCnt;
    busIdle(); ticks(8);
    @(negedge clk); sdaIn = 1'b0; idle(4);
    ticks(3);
    @(negedge clk); sdaIn = 1'b1; idle(4);
    ticks(5); idle(2);
    chk("R10 hold restarted", irqCnt - i0, 0);
    ticks(1); idle(2);
    chk("R10 stop reported", stopCnt - p0, 1);
    chk("R10 start dropped", startCnt - s0, 0);
    chk("R10 busy cleared", busBusy, 0);
  endtask

  initial begin
    idle(3);
    t_reset();
    rstN = 1'b1;
    idle(3);
    t_start_exact();
    t_stop();
    t_setup_short();
    t_hold_abort();
    t_no_tick();
    t_scl_low_edges();
    t_replace();
    chk("R8 irq never wider than one cycle", wideIrq, 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule